// File: doc/BRIEF.md
# Self-Correcting Triplicated State Register

This block keeps a small piece of state, here a counter of parameterised width, in three flip-flop copies that share one clock. Each copy is driven by its own logic leg, and each leg has its own enable, load strobe and load value. Before a leg computes its next state, it passes all three copies through its own bitwise majority voter. A copy that has been upset is therefore rebuilt from the other two at the next clock edge. It cannot stay wrong.

A final voter built in multiplexer form produces the single hardened output. Copies A and B act as selects: where they agree, their common value is passed; where they disagree, copy C is passed. A mismatch flag shows any cycle in which the three raw copies are not all equal. A test-only bit-flip mask on each leg lets a bench corrupt one copy on purpose.

Top module: `tmr_state_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all three copies to zero at once. After that edge `q` is 0 and `mismatch` is 0, whatever the other inputs were.
- R2: When a leg's enable is 1 and its load strobe is 0, that leg's next state is its voted state plus one, modulo 2^WIDTH. With all legs driven alike, `q` goes from all-ones to 0.
- R3: A leg's load strobe takes priority over its enable. The leg's next state is then its load value.
- R4: When a leg's enable and load strobe are both 0, its next state equals its voted state, so `q` holds.
- R5: The output is voted bit by bit. Where copy A and copy B hold the same bit value, `q` takes that value. Where they differ, `q` takes copy C's bit. As a result, one corrupted copy never changes `q`, even in the cycle in which it is wrong.
- R6: `mismatch` is 1 in exactly those cycles in which the three registered copies are not all equal.
- R7: A nonzero injection mask on a leg, present at a rising edge without reset, is XORed into the value that leg registers at that edge. Reset overrides injection.
- R8: Every leg feeds back the majority-voted state, not its own register. A single corrupted copy therefore agrees with the other two again one clock later, as long as the legs' inputs agree.
- R9: A wrong enable, load strobe or load value on one leg alone leaves `q` correct. It shows only as `mismatch` for the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for all three copies |
| rst | input | 1 | Synchronous reset, active high |
| en_a | input | 1 | Count enable, leg A |
| en_b | input | 1 | Count enable, leg B |
| en_c | input | 1 | Count enable, leg C |
| ld_a | input | 1 | Load strobe, leg A |
| ld_b | input | 1 | Load strobe, leg B |
| ld_c | input | 1 | Load strobe, leg C |
| ld_val_a | input | WIDTH | Load value, leg A |
| ld_val_b | input | WIDTH | Load value, leg B |
| ld_val_c | input | WIDTH | Load value, leg C |
| inj_a | input | WIDTH | Test bit-flip mask, leg A |
| inj_b | input | WIDTH | Test bit-flip mask, leg B |
| inj_c | input | WIDTH | Test bit-flip mask, leg C |
| q | output | WIDTH | Voted state |
| mismatch | output | 1 | High while the three copies are not all equal |

## Verification
A wrong copy is hidden at `q` by design. It becomes visible at the ports only through `mismatch`, which rises in the same cycle as the corruption and must fall one edge later. A broken feedback voter would leave `mismatch` high for a second cycle. A broken output voter would put a wrong count on `q` in the very cycle of the upset. For this reason the bench checks both outputs after every edge, against a model of three legs voted by bit counts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_COPIES = 3;
  typedef enum logic [1:0] {LEG_A = 2'd0, LEG_B = 2'd1, LEG_C = 2'd2} leg_e;
endpackage

// File: rtl/tmr_maj_voter.sv
module tmr_maj_voter #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  function automatic logic [W-1:0] maj3(input logic [W-1:0] x0,
                                        input logic [W-1:0] x1,
                                        input logic [W-1:0] x2);
    return (x0 & x1) | (x1 & x2) | (x0 & x2);
  endfunction

  assign y = maj3(a, b, c);
endmodule

// File: rtl/tmr_mux_voter.sv
module tmr_mux_voter #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] sel_a,
  input  logic [W-1:0] sel_b,
  input  logic [W-1:0] pass_c,
  output logic [W-1:0] y
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      always_comb begin
        unique case ({sel_a[i], sel_b[i]})
          2'b00:   y[i] = 1'b0;
          2'b11:   y[i] = 1'b1;
          default: y[i] = pass_c[i];
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/tmr_leg.sv
module tmr_leg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] inj_mask,
  input  logic [W-1:0] fb_voted,
  output logic [W-1:0] copy_q
);
  function automatic logic [W-1:0] step_count(input logic [W-1:0] cur,
                                              input logic         e,
                                              input logic         l,
                                              input logic [W-1:0] lv);
    if (l)      return lv;
    else if (e) return cur + W'(1);
    else        return cur;
  endfunction

  logic [W-1:0] next_state;
  assign next_state = step_count(fb_voted, en, ld, ld_val) ^ inj_mask;

  always_ff @(posedge clk) begin
    if (rst) copy_q <= '0;
    else     copy_q <= next_state;
  end

  // R7: an injected mask lands in this leg's register
  assert_inj_lands_R7: assert property (@(posedge clk) disable iff (rst)
    (inj_mask != '0) |=> (copy_q != step_count($past(fb_voted), $past(en), $past(ld), $past(ld_val))));
endmodule

// File: rtl/tmr_state_reg.sv
module tmr_state_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_a,
  input  logic             en_b,
  input  logic             en_c,
  input  logic             ld_a,
  input  logic             ld_b,
  input  logic             ld_c,
  input  logic [WIDTH-1:0] ld_val_a,
  input  logic [WIDTH-1:0] ld_val_b,
  input  logic [WIDTH-1:0] ld_val_c,
  input  logic [WIDTH-1:0] inj_a,
  input  logic [WIDTH-1:0] inj_b,
  input  logic [WIDTH-1:0] inj_c,
  output logic [WIDTH-1:0] q,
  output logic             mismatch
);
  import tmr_pkg::*;

  logic [TMR_COPIES-1:0]            leg_en, leg_ld;
  logic [TMR_COPIES-1:0][WIDTH-1:0] leg_val, leg_inj, copies, fb;

  assign leg_en  = {en_c, en_b, en_a};
  assign leg_ld  = {ld_c, ld_b, ld_a};
  assign leg_val = {ld_val_c, ld_val_b, ld_val_a};
  assign leg_inj = {inj_c, inj_b, inj_a};

  genvar g;
  generate
    for (g = 0; g < TMR_COPIES; g++) begin : g_leg
      tmr_maj_voter #(.W(WIDTH)) u_fb_vote (
        .a(copies[LEG_A]), .b(copies[LEG_B]), .c(copies[LEG_C]), .y(fb[g])
      );
      tmr_leg #(.W(WIDTH)) u_leg (
        .clk(clk), .rst(rst), .en(leg_en[g]), .ld(leg_ld[g]),
        .ld_val(leg_val[g]), .inj_mask(leg_inj[g]),
        .fb_voted(fb[g]), .copy_q(copies[g])
      );
    end
  endgenerate

  tmr_mux_voter #(.W(WIDTH)) u_out_vote (
    .sel_a(copies[LEG_A]), .sel_b(copies[LEG_B]), .pass_c(copies[LEG_C]), .y(q)
  );

  assign mismatch = (copies[LEG_A] != copies[LEG_B]) || (copies[LEG_B] != copies[LEG_C]);

  // Named events for the assertions
  logic ctl_agree, all_count, all_load, all_hold, single_fault;
  assign ctl_agree = (leg_en == '0 || leg_en == '1) && (leg_ld == '0 || leg_ld == '1)
                     && (ld_val_a == ld_val_b) && (ld_val_b == ld_val_c)
                     && (leg_inj == '0);
  assign all_count    = ctl_agree && leg_en[LEG_A] && !leg_ld[LEG_A];
  assign all_load     = ctl_agree && leg_ld[LEG_A];
  assign all_hold     = ctl_agree && !leg_en[LEG_A] && !leg_ld[LEG_A];
  assign single_fault = (copies[LEG_A] == copies[LEG_B]) && mismatch;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (q == '0) && !mismatch);
  assert_count_up_R2: assert property (@(posedge clk) disable iff (rst)
    all_count |=> q == $past(q) + WIDTH'(1));
  assert_load_wins_R3: assert property (@(posedge clk) disable iff (rst)
    all_load |=> q == $past(ld_val_a));
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    all_hold |=> $stable(q));
  assert_mask_c_R5: assert property (@(posedge clk) disable iff (rst)
    single_fault |-> q == copies[LEG_A]);
  assert_agree_out_R6: assert property (@(posedge clk) disable iff (rst)
    !mismatch |-> (q == copies[LEG_B]));
  assert_recover_R8: assert property (@(posedge clk) disable iff (rst)
    ctl_agree |=> !mismatch);
endmodule

// File: tb/tb_tmr_state_reg.sv
module tb_tmr_state_reg;
  localparam int unsigned W = 4;
  localparam time CLK_PERIOD = 10;
  localparam int N_VEC = 14;

  // vector: rst, en[2:0], ld[2:0], ldv_a, ldv_b, ldv_c, inj_a, inj_b, inj_c
  localparam int VW = 1 + 3 + 3 + 6 * W;
  localparam logic [VW-1:0] VEC [N_VEC] = '{
    {1'b0, 3'b111, 3'b000, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0}, // R2 count
    {1'b0, 3'b111, 3'b000, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0}, // R2
    {1'b0, 3'b000, 3'b111, 4'h9, 4'h9, 4'h9, 4'h0, 4'h0, 4'h0}, // R3 load
    {1'b0, 3'b111, 3'b000, 4'h0, 4'h0, 4'h0, 4'h5, 4'h0, 4'h0}, // R7 inject A
    {1'b0, 3'b111, 3'b000, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0}, // R8 recover
    {1'b0, 3'b011, 3'b000, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0}, // R9 en_c stuck
    {1'b0, 3'b111, 3'b000, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0}, // R8
    {1'b0, 3'b111, 3'b100, 4'h0, 4'h0, 4'h3, 4'h0, 4'h0, 4'h0}, // R9 stray load C
    {1'b0, 3'b111, 3'b000, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0}, // R2
    {1'b0, 3'b111, 3'b000, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0}, // R2 wrap
    {1'b0, 3'b000, 3'b000, 4'h0, 4'h0, 4'h0, 4'h0, 4'hF, 4'h0}, // R4 hold + R7 inject B
    {1'b0, 3'b111, 3'b111, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0}, // R3 load over enable
    {1'b0, 3'b111, 3'b000, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h8}, // R5 inject C, wrap
    {1'b1, 3'b111, 3'b000, 4'h0, 4'h0, 4'h0, 4'h3, 4'h0, 4'h0}  // R1 reset beats inject
  };

  logic clk = 1'b0;
  logic rst;
  logic en_a, en_b, en_c, ld_a, ld_b, ld_c;
  logic [W-1:0] ld_val_a, ld_val_b, ld_val_c, inj_a, inj_b, inj_c;
  logic [W-1:0] q;
  logic mismatch;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] mv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tmr_state_reg #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .en_a(en_a), .en_b(en_b), .en_c(en_c),
    .ld_a(ld_a), .ld_b(ld_b), .ld_c(ld_c),
    .ld_val_a(ld_val_a), .ld_val_b(ld_val_b), .ld_val_c(ld_val_c),
    .inj_a(inj_a), .inj_b(inj_b), .inj_c(inj_c),
    .q(q), .mismatch(mismatch)
  );

  function automatic logic [W-1:0] leg_model(input logic [W-1:0] v, input logic e,
                                              input logic l, input logic [W-1:0] lv);
    logic [W-1:0] r;
    r = v;
    if (e) r = v + 1;
    if (l) r = lv;
    return r;
  endfunction

  function automatic logic [W-1:0] vote_by_count(input logic [W-1:0] x, input logic [W-1:0] y,
                                                  input logic [W-1:0] z);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      int n;
      n = int'(x[i]) + int'(y[i]) + int'(z[i]);
      r[i] = (n >= 2);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp_q, input logic exp_mis);
    checks++;
    if (q !== exp_q) begin
      errors++;
      $display("FAIL %s: q actual=%h expected=%h", req, q, exp_q);
    end
    checks++;
    if (mismatch !== exp_mis) begin
      errors++;
      $display("FAIL %s: mismatch actual=%b expected=%b", req, mismatch, exp_mis);
    end
  endtask

  task automatic apply(input logic [VW-1:0] v, input string req);
    logic [W-1:0] la, lb, lc, eq;
    @(negedge clk);
    {rst, en_c, en_b, en_a, ld_c, ld_b, ld_a, ld_val_a, ld_val_b, ld_val_c,
     inj_a, inj_b, inj_c} = v;
    la = leg_model(mv, en_a, ld_a, ld_val_a) ^ inj_a;
    lb = leg_model(mv, en_b, ld_b, ld_val_b) ^ inj_b;
    lc = leg_model(mv, en_c, ld_c, ld_val_c) ^ inj_c;
    if (rst) begin la = '0; lb = '0; lc = '0; end
    eq = vote_by_count(la, lb, lc);
    mv = eq;
    @(posedge clk);
    #1;
    check(req, eq, !((la == lb) && (lb == lc)));
  endtask

  task automatic idle_inputs();
    {en_a, en_b, en_c, ld_a, ld_b, ld_c} = '0;
    {ld_val_a, ld_val_b, ld_val_c, inj_a, inj_b, inj_c} = '0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    rst = 1'b1;
    idle_inputs();
    mv = '0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset state", '0, 1'b0);

    for (int k = 0; k < N_VEC; k++) apply(VEC[k], "R2-R9 vector");

    // R1: reset from a nonzero, disagreeing state
    apply({1'b0, 3'b111, 3'b111, 4'hA, 4'hA, 4'hA, 4'h0, 4'h0, 4'h0}, "R3 load A");
    apply({1'b0, 3'b000, 3'b000, 4'h0, 4'h0, 4'h0, 4'h0, 4'h6, 4'h0}, "R7 inject B");
    apply({1'b1, 3'b111, 3'b111, 4'h7, 4'h7, 4'h7, 4'h1, 4'h2, 4'h4}, "R1 reset clears");

    // R5: corrupt C every other cycle, q must follow the clean count
    for (int k = 0; k < 6; k++)
      apply({1'b0, 3'b111, 3'b000, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0,
             (k % 2 == 0) ? 4'hF : 4'h0}, "R5 mask C");

    // R9: wrong load value on leg A only
    apply({1'b0, 3'b000, 3'b111, 4'h2, 4'hC, 4'hC, 4'h0, 4'h0, 4'h0}, "R9 bad value A");
    apply({1'b0, 3'b000, 3'b000, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0}, "R8 R4 hold after");

    // R2: wrap from all-ones
    apply({1'b0, 3'b000, 3'b111, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0}, "R3 load F");
    apply({1'b0, 3'b111, 3'b000, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0}, "R2 wrap to 0");

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule